// File: doc/BRIEF.md
# Memory Bandwidth Monitor with Port Filters

This block sits next to a memory controller's arbiter and measures traffic. On every clock it sees two event strobes from the arbiter: a request strobe, and a grant strobe that carries the granting master's port number and, for the one shared device port, a sub-port number. Two global counters count requests and grants. Four monitor channels each count the grants that come from a set of masters chosen by software.

Each channel has a two-level filter. The first level is a primary mask with one bit per master port. When the primary bit of the shared device port is set, the second level applies: a 16-bit sub-port mask chooses which devices behind that port are counted. Counting can run freely. It can also be bounded by a one-shot window of programmable length in clock cycles. When the window closes, the counters freeze and an interrupt is raised. The window starts again only when software writes the enable again. One count stands for 16 bytes moved.

Software uses a simple 32-bit word-addressed register port. The byte offset of a register is its word index times four.

Top module: `bw_monitor`

## Requirements
- R1: After reset every register reads zero and `irq_o` is low.
- R2: Registers sit at these byte offsets. The control word is at 0x80. The filter words for channel c are at 0x84+8c (primary mask, all 32 bits) and 0x88+8c (sub-port mask, bits 15:0; the upper bits read 0). The request count is at 0xA4. The grant count is at 0xA8. The grant count of channel c is at 0xAC+4c. The window length is at 0xBC. In the control word, bit 31 is the enable, bit 30 is the window-done flag, bit 20 is the window mode and bits 3:0 are the channel enables. All other control bits read 0.
- R3: While monitoring is active (enable set and done flag clear), each cycle with `req_valid_i` high adds one to the request count.
- R4: While monitoring is active, each cycle with `gnt_valid_i` high adds one to the grant count.
- R5: For a port other than 23, a grant adds one to channel c when bit c of the channel enables is set and bit `gnt_port_i` of the channel's primary mask is set.
- R6: A grant from port 23 adds one to channel c only when the channel is enabled, primary bit 23 is set and bit `gnt_sub_i` of the channel's sub-port mask is set.
- R7: One grant can add one to several channels in the same cycle, and to the grant count as well.
- R8: A control write with bit 31 set starts a window. If the window mode is set and the length register holds L, counting takes place on the max(L,1) following clock edges. On the last of these edges the done flag is set and `irq_o` goes high. After that no counter changes until the next control write.
- R9: Any control write clears the done flag and `irq_o`. A control write with bit 31 set also clears every count register in the same edge. So writing back the value read starts a fresh window.
- R10: With the window mode clear, counting runs for as long as the enable is set, and `irq_o` stays low.
- R11: A write to a count register loads the written value. Counters saturate at 0xFFFFFFFF and never wrap.
- R12: With the enable clear, or a channel enable bit clear, the affected counters do not change. Writing zero to both filter words of a channel stops that channel from counting.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Memory clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 8 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data (combinational on address) |
| req_valid_i | input | 1 | Arbiter request event |
| gnt_valid_i | input | 1 | Arbiter grant event |
| gnt_port_i | input | 5 | Master port of the grant |
| gnt_sub_i | input | 4 | Sub-port of the grant on the shared port |
| irq_o | output | 1 | Window-done interrupt |

## Verification
The bound checker checks several properties on every cycle. Counts stay frozen while the interrupt is pending or while the enable is clear. The grant count never rises by more than one per cycle. A saturated count stays at all-ones. The interrupt never rises when the window mode is off. The bench scenarios show what a per-cycle property cannot: the filter decode for each channel (including the sub-port level and grants that hit several channels), the exact window length with its zero-length boundary, the clearing of the counters by a write-back restart, and saturation reached through traffic.

// File: rtl/bwm_pkg.sv
package bwm_pkg;
  localparam int NUM_CH    = 4;
  localparam int REG_W     = 32;
  localparam int IDX_CTRL  = 'h20;
  localparam int IDX_REQ   = 'h29;
  localparam int IDX_GNT   = 'h2A;
  localparam int IDX_CH0   = 'h2B;
  localparam int IDX_TIMER = 'h2F;
  localparam int BIT_EN    = 31;
  localparam int BIT_DONE  = 30;
  localparam int BIT_TMODE = 20;
endpackage

// File: rtl/bwm_port_filter.sv
module bwm_port_filter #(
  parameter int PORT_W   = 5,
  parameter int SUB_W    = 4,
  parameter int DEV_PORT = 23
) (
  input  logic [(2**PORT_W)-1:0] prim_mask_i,
  input  logic [(2**SUB_W)-1:0]  sub_mask_i,
  input  logic [PORT_W-1:0]      port_i,
  input  logic [SUB_W-1:0]       sub_i,
  output logic                   match_o
);
  always_comb begin
    if (port_i == PORT_W'(DEV_PORT)) match_o = prim_mask_i[DEV_PORT] & sub_mask_i[sub_i];
    else                             match_o = prim_mask_i[port_i];
  end
endmodule

// File: rtl/bwm_sat_counter.sv
module bwm_sat_counter #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         wr_i,
  input  logic [W-1:0] wdata_i,
  input  logic         inc_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                   cnt_o <= '0;
    else if (clr_i)                cnt_o <= '0;
    else if (wr_i)                 cnt_o <= wdata_i;
    else if (inc_i && cnt_o != '1) cnt_o <= cnt_o + W'(1);
  end
endmodule

// File: rtl/bwm_window_timer.sv
module bwm_window_timer #(
  parameter int W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] len_i,
  input  logic         run_i,
  output logic         expire_o
);
  logic [W-1:0] rem_q;

  // last counted edge when one or zero cycles remain
  assign expire_o = run_i && (rem_q <= W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       rem_q <= '0;
    else if (load_i)   rem_q <= len_i;
    else if (expire_o) rem_q <= '0;
    else if (run_i)    rem_q <= rem_q - W'(1);
  end
endmodule

// File: rtl/bw_monitor.sv
module bw_monitor
  import bwm_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int CNT_W    = 32,
  parameter int PORT_W   = 5,
  parameter int SUB_W    = 4,
  parameter int DEV_PORT = 23
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [REG_W-1:0]  reg_wdata_i,
  output logic [REG_W-1:0]  reg_rdata_o,
  input  logic              req_valid_i,
  input  logic              gnt_valid_i,
  input  logic [PORT_W-1:0] gnt_port_i,
  input  logic [SUB_W-1:0]  gnt_sub_i,
  output logic              irq_o
);
  localparam int IDX_W  = ADDR_W - 2;
  localparam int PORT_N = 2**PORT_W;
  localparam int SUB_N  = 2**SUB_W;

  logic [IDX_W-1:0] word;
  logic             aligned, wr_any, wr_ctrl, start;
  logic             en_q, tmode_q, done_q, active, expire;
  logic [NUM_CH-1:0] chen_q;
  logic [CNT_W-1:0] timer_len_q, all_req_q, all_gnt_q;
  logic [PORT_N-1:0] prim_q [NUM_CH];
  logic [SUB_N-1:0]  sub_q  [NUM_CH];
  logic [CNT_W-1:0]  ch_cnt [NUM_CH];

  assign word    = reg_addr_i[ADDR_W-1:2];
  assign aligned = (reg_addr_i[1:0] == 2'b00);
  assign wr_any  = reg_wr_i && aligned;
  assign wr_ctrl = wr_any && (word == IDX_W'(IDX_CTRL));
  assign start   = wr_ctrl && reg_wdata_i[BIT_EN];
  assign active  = en_q && !done_q;
  assign irq_o   = done_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q    <= 1'b0;
      tmode_q <= 1'b0;
      chen_q  <= '0;
      done_q  <= 1'b0;
    end else if (wr_ctrl) begin
      en_q    <= reg_wdata_i[BIT_EN];
      tmode_q <= reg_wdata_i[BIT_TMODE];
      chen_q  <= reg_wdata_i[NUM_CH-1:0];
      done_q  <= 1'b0;
    end else if (expire) begin
      done_q  <= 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                      timer_len_q <= '0;
    else if (wr_any && word == IDX_W'(IDX_TIMER))     timer_len_q <= reg_wdata_i[CNT_W-1:0];
  end

  bwm_window_timer #(.W(CNT_W)) u_timer (
    .clk_i, .rst_ni,
    .load_i  (start),
    .len_i   (timer_len_q),
    .run_i   (active && tmode_q),
    .expire_o(expire)
  );

  bwm_sat_counter #(.W(CNT_W)) u_req_cnt (
    .clk_i, .rst_ni,
    .clr_i  (start),
    .wr_i   (wr_any && word == IDX_W'(IDX_REQ)),
    .wdata_i(reg_wdata_i[CNT_W-1:0]),
    .inc_i  (active && req_valid_i),
    .cnt_o  (all_req_q)
  );

  bwm_sat_counter #(.W(CNT_W)) u_gnt_cnt (
    .clk_i, .rst_ni,
    .clr_i  (start),
    .wr_i   (wr_any && word == IDX_W'(IDX_GNT)),
    .wdata_i(reg_wdata_i[CNT_W-1:0]),
    .inc_i  (active && gnt_valid_i),
    .cnt_o  (all_gnt_q)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic match;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        prim_q[c] <= '0;
        sub_q[c]  <= '0;
      end else begin
        if (wr_any && word == IDX_W'(IDX_CTRL + 1 + 2*c)) prim_q[c] <= reg_wdata_i[PORT_N-1:0];
        if (wr_any && word == IDX_W'(IDX_CTRL + 2 + 2*c)) sub_q[c]  <= reg_wdata_i[SUB_N-1:0];
      end
    end

    bwm_port_filter #(.PORT_W(PORT_W), .SUB_W(SUB_W), .DEV_PORT(DEV_PORT)) u_filt (
      .prim_mask_i(prim_q[c]),
      .sub_mask_i (sub_q[c]),
      .port_i     (gnt_port_i),
      .sub_i      (gnt_sub_i),
      .match_o    (match)
    );

    bwm_sat_counter #(.W(CNT_W)) u_cnt (
      .clk_i, .rst_ni,
      .clr_i  (start),
      .wr_i   (wr_any && word == IDX_W'(IDX_CH0 + c)),
      .wdata_i(reg_wdata_i[CNT_W-1:0]),
      .inc_i  (active && gnt_valid_i && chen_q[c] && match),
      .cnt_o  (ch_cnt[c])
    );
  end

  always_comb begin
    reg_rdata_o = '0;
    if (aligned) begin
      if (word == IDX_W'(IDX_CTRL)) begin
        reg_rdata_o[BIT_EN]       = en_q;
        reg_rdata_o[BIT_DONE]     = done_q;
        reg_rdata_o[BIT_TMODE]    = tmode_q;
        reg_rdata_o[NUM_CH-1:0]   = chen_q;
      end
      if (word == IDX_W'(IDX_REQ))   reg_rdata_o = REG_W'(all_req_q);
      if (word == IDX_W'(IDX_GNT))   reg_rdata_o = REG_W'(all_gnt_q);
      if (word == IDX_W'(IDX_TIMER)) reg_rdata_o = REG_W'(timer_len_q);
      for (int c = 0; c < NUM_CH; c++) begin
        if (word == IDX_W'(IDX_CTRL + 1 + 2*c)) reg_rdata_o = REG_W'(prim_q[c]);
        if (word == IDX_W'(IDX_CTRL + 2 + 2*c)) reg_rdata_o = REG_W'(sub_q[c]);
        if (word == IDX_W'(IDX_CH0 + c))        reg_rdata_o = REG_W'(ch_cnt[c]);
      end
    end
  end
endmodule

// File: rtl/bw_monitor_chk.sv
module bw_monitor_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             reg_wr_i,
  input logic             irq_i,
  input logic             en_i,
  input logic             tmode_i,
  input logic [CNT_W-1:0] all_req_i,
  input logic [CNT_W-1:0] all_gnt_i
);
  AST_GNT_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reg_wr_i |=> (all_gnt_i - $past(all_gnt_i)) <= CNT_W'(1)); // R4

  AST_FROZEN_AFTER_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i && !reg_wr_i) |=> ($stable(all_req_i) && $stable(all_gnt_i))); // R8

  AST_NO_FREE_RUN_IRQ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tmode_i && !irq_i && !reg_wr_i) |=> !irq_i); // R10

  AST_SAT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (all_gnt_i == '1 && !reg_wr_i) |=> all_gnt_i == '1); // R11

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !reg_wr_i) |=> ($stable(all_req_i) && $stable(all_gnt_i))); // R12
endmodule

bind bw_monitor bw_monitor_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .reg_wr_i (reg_wr_i),
  .irq_i    (irq_o),
  .en_i     (en_q),
  .tmode_i  (tmode_q),
  .all_req_i(all_req_q),
  .all_gnt_i(all_gnt_q)
);

// File: tb/bw_monitor_test.sv
module bw_monitor_test;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_wr_i = 1'b0;
  logic [7:0]  reg_addr_i = '0;
  logic [31:0] reg_wdata_i = '0;
  logic [31:0] reg_rdata_o;
  logic        req_valid_i = 1'b0, gnt_valid_i = 1'b0;
  logic [4:0]  gnt_port_i = '0;
  logic [3:0]  gnt_sub_i = '0;
  logic        irq_o;

  int vectors = 0, miscompares = 0;
  bit done = 1'b0;

  localparam logic [7:0] A_CTRL = 8'h80, A_REQ = 8'hA4, A_GNT = 8'hA8, A_TMR = 8'hBC, A_IRQ = 8'hFF;

  logic [7:0]  q_addr [$];
  logic [31:0] q_exp  [$];
  string       q_tag  [$];

  always #10 clk_i = ~clk_i;

  bw_monitor uut (.*);

  function automatic logic [7:0] a_prim(int c); return 8'(8'h84 + 8*c); endfunction
  function automatic logic [7:0] a_sub(int c);  return 8'(8'h88 + 8*c); endfunction
  function automatic logic [7:0] a_cnt(int c);  return 8'(8'hAC + 4*c); endfunction

  // all tasks start and end on a falling edge
  task automatic wr(logic [7:0] a, logic [31:0] d);
    reg_wr_i = 1'b1; reg_addr_i = a; reg_wdata_i = d;
    @(negedge clk_i);
    reg_wr_i = 1'b0;
  endtask

  task automatic ev(logic r, logic g, logic [4:0] p, logic [3:0] s, int n);
    req_valid_i = r; gnt_valid_i = g; gnt_port_i = p; gnt_sub_i = s;
    repeat (n) @(negedge clk_i);
    req_valid_i = 1'b0; gnt_valid_i = 1'b0;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk_i);
  endtask

  task automatic chk(logic [7:0] a, logic [31:0] e, string tag);
    reg_addr_i = (a == A_IRQ) ? 8'h00 : a;
    q_addr.push_back(a); q_exp.push_back(e); q_tag.push_back(tag);
    @(negedge clk_i);
  endtask

  // monitor: compares what the driver queued
  initial begin
    forever begin
      @(negedge clk_i);
      #2;
      while (q_exp.size() > 0) begin
        logic [7:0]  a;
        logic [31:0] e, act;
        string       t;
        a = q_addr.pop_front(); e = q_exp.pop_front(); t = q_tag.pop_front();
        act = (a == A_IRQ) ? {31'b0, irq_o} : reg_rdata_o;
        vectors++;
        if (act !== e) begin
          miscompares++;
          $display("FAIL %s addr=%h actual=%h expected=%h", t, a, act, e);
        end
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk_i);
    if (!done) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    idle(3);
    rst_ni = 1'b1;
    idle(1);
    // R1 reset state
    chk(A_CTRL, 0, "R1 ctrl");
    chk(A_GNT, 0, "R1 gnt");
    chk(a_cnt(0), 0, "R1 ch0");
    chk(A_IRQ, 0, "R1 irq");

    // R2 filter programming and readback
    wr(a_prim(0), 32'h0000_0004);
    wr(a_prim(1), 32'h0080_0004);
    wr(a_sub(1), 32'hFFFF_0005);
    wr(a_prim(2), 32'h0080_0000);
    wr(a_sub(2), 32'h0000_0002);
    wr(a_prim(3), 32'h0000_0080);
    chk(a_sub(1), 32'h0000_0005, "R2 sub mask width");
    chk(a_prim(1), 32'h0080_0004, "R2 primary readback");

    // R12 not enabled: nothing counts
    ev(1, 1, 5'd2, 0, 2);
    chk(A_GNT, 0, "R12 disabled gnt");
    chk(A_REQ, 0, "R12 disabled req");

    // free run, channels 0..2 enabled
    wr(A_CTRL, 32'h8000_0007);
    chk(A_CTRL, 32'h8000_0007, "R2 ctrl readback");
    ev(1, 0, 0, 0, 3);
    ev(0, 1, 5'd2, 0, 2);
    ev(0, 1, 5'd23, 4'd0, 1);
    ev(0, 1, 5'd23, 4'd1, 1);
    ev(0, 1, 5'd23, 4'd2, 1);
    ev(0, 1, 5'd7, 0, 1);
    ev(0, 1, 5'd23, 4'd9, 1);
    chk(A_REQ, 3, "R3 req count");
    chk(A_GNT, 7, "R4 gnt count");
    chk(a_cnt(0), 2, "R5 ch0 primary match");
    chk(a_cnt(1), 4, "R7 ch1 shared with ch0 and sub-ports");
    chk(a_cnt(2), 1, "R6 ch2 sub-port filter");
    chk(a_cnt(3), 0, "R12 ch3 disabled");
    chk(A_IRQ, 0, "R10 no irq in free run");

    // R12 clearing filter words removes sources
    wr(a_prim(1), 0);
    wr(a_sub(1), 0);
    ev(0, 1, 5'd2, 0, 1);
    chk(a_cnt(1), 4, "R12 cleared filter");
    chk(a_cnt(0), 3, "R5 ch0 after more");

    // R11 write and saturate
    wr(A_GNT, 32'hFFFF_FFFE);
    chk(A_GNT, 32'hFFFF_FFFE, "R11 count write");
    ev(0, 1, 5'd2, 0, 3);
    chk(A_GNT, 32'hFFFF_FFFF, "R11 saturate gnt");
    chk(a_cnt(0), 6, "R11 ch0 below limit");
    wr(a_cnt(0), 32'hFFFF_FFFF);
    ev(0, 1, 5'd2, 0, 2);
    chk(a_cnt(0), 32'hFFFF_FFFF, "R11 saturate ch0");

    // R12 stop with zero control
    wr(A_GNT, 0);
    wr(A_CTRL, 0);
    ev(1, 1, 5'd2, 0, 2);
    chk(A_GNT, 0, "R12 stopped gnt");
    chk(A_CTRL, 0, "R12 stopped ctrl");

    // R8 timer window of 5
    wr(A_TMR, 5);
    chk(A_TMR, 5, "R2 timer readback");
    wr(A_CTRL, 32'h8010_0001);
    ev(1, 1, 5'd2, 0, 8);
    chk(A_GNT, 5, "R8 window length");
    chk(A_REQ, 5, "R8 req in window");
    chk(a_cnt(0), 5, "R9 start cleared ch0");
    chk(A_IRQ, 1, "R8 irq");
    chk(A_CTRL, 32'hC010_0001, "R8 done flag");

    // R9 write back restarts
    wr(A_CTRL, 32'hC010_0001);
    chk(A_IRQ, 0, "R9 irq cleared");
    chk(a_cnt(0), 0, "R9 counters cleared");
    idle(6);
    chk(A_IRQ, 1, "R8 second window expired");
    ev(1, 1, 5'd2, 0, 2);
    chk(a_cnt(0), 0, "R8 frozen ch0");
    chk(A_GNT, 0, "R8 frozen gnt");

    // R8 zero length counts one edge
    wr(A_TMR, 0);
    wr(A_CTRL, 32'h8010_0001);
    ev(0, 1, 5'd2, 0, 3);
    chk(A_GNT, 1, "R8 zero length window");
    chk(A_IRQ, 1, "R8 zero length irq");
    wr(A_CTRL, 0);
    chk(A_IRQ, 0, "R9 stop clears irq");

    idle(2);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule